// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block sits between an 8-bit microcontroller core and its external memory. It handles every code fetch and every data access the core issues in a 16-bit address space. A code fetch is served either by the on-chip 4 KB program ROM or by the external bus. The choice depends on an external-access input and on whether the address lies below 1000H. Data reads and writes always go out on the external bus.

An external access uses a multiplexed port. In the opening phase the shared 8-bit port carries the low address byte while an address latch strobe is high, so an outside latch can capture it. A separate port carries the high address byte for the whole access. After the latch strobe drops, one strobe goes low for a fixed number of clocks:

- the program-store strobe for code fetches,
- the read strobe for data reads,
- the write strobe for data writes.

During a write the shared port carries the write byte. During a read or fetch the port is released, and the incoming byte is sampled on the last strobe cycle. The core sees a busy signal that holds off new requests and a one-cycle done pulse that carries the result.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request pending, `psen_n`, `rd_n` and `wr_n` are high, `ale` is low, `ad_oe` is low, `busy` is low and `done` is low.
- R2: With `ext_access` low, a code fetch (`req_kind` = 0) to any address from 0000H to FFFFH runs an external access with `psen_n` as its strobe.
- R3: With `ext_access` high, a code fetch below 1000H is internal. `rom_addr` equals `req_addr[11:0]` while the request is presented. `done` is high in the cycle after acceptance, with `rdata` equal to `rom_data`. No strobe, no `ale` and no `busy` occur.
- R4: With `ext_access` high, a code fetch at 1000H or above runs an external access with `psen_n` as its strobe.
- R5: An external access starts in the cycle after acceptance. It drives `ale` high for ALE_CYC (default 2) cycles with `ad_oe` high and `ad_out` equal to the low address byte. `a_hi` equals the high address byte through the whole access.
- R6: After `ale` falls, the low address stays driven for one more cycle with all strobes high. Exactly one strobe is then low for STB_CYC (default 3) consecutive cycles, and `ale` is never high while a strobe is low.
- R7: At most one of `psen_n`, `rd_n` and `wr_n` is low at any time.
- R8: A data write (`req_kind` = 2) lowers only `wr_n`. Throughout the `wr_n`-low interval, `ad_oe` is high and `ad_out` equals `req_wdata`.
- R9: During a fetch or data read strobe, `ad_oe` is low. `rdata` takes the `ad_in` value present on the last strobe cycle, and `done` pulses for one cycle right after the strobe rises.
- R10: `busy` is high from the first address cycle through the last strobe cycle of an external access. A request presented while `busy` is high is ignored, and no second access follows it.
- R11: A data read (`req_kind` = 1) or data write always uses the external bus, whatever the address and `ext_access`. Reads lower only `rd_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core presents a request; taken when busy is low |
| req_kind | input | 2 | 0 code fetch, 1 data read, 2 data write |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Byte to write |
| ext_access | input | 1 | High: the low 4 KB of code comes from on-chip ROM |
| busy | output | 1 | External access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Fetched or read byte, valid with done |
| rom_addr | output | 12 | Address to the on-chip ROM |
| rom_data | input | 8 | Byte from the on-chip ROM, combinational on rom_addr |
| ad_out | output | 8 | Shared port, driven value |
| ad_oe | output | 1 | Shared port drive enable |
| ad_in | input | 8 | Shared port, received value |
| a_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The hardest case to reach is a request arriving while an external access is already in its strobe phase. The busy gating must then discard it without shortening or disturbing the running access. To reach it, the bench raises `req_valid` with a different address in the first strobe cycle of every external transaction. It then checks that the strobe still lasts its full length, that `done` pulses only once, and that no new address phase follows. A sweep crosses both `ext_access` levels with all three request kinds over boundary addresses (0000H, 0FFFH, 1000H, FFFFH) and a strided set. This covers the internal/external split on either side of 1000H.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2
  } xbus_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_HOLD = 2'd2,
    ST_STRB = 2'd3
  } xbus_state_e;

endpackage

// File: rtl/xbus_steer.sv
module xbus_steer
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ROM_AW = 12
) (
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ext_access,
  output logic              go_internal
);
  localparam int UPPER_W = ADDR_W - ROM_AW;

  logic below_rom_top;

  // The address lies inside the on-chip ROM window when every bit above it is zero.
  always_comb begin
    below_rom_top = (addr[ADDR_W-1 -: UPPER_W] == '0);
    go_internal   = (kind == KIND_FETCH) && ext_access && below_rom_top;
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ALE_CYC = 2,
  parameter int STB_CYC = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_ext,
  output xbus_state_e state,
  output logic        last_strb
);
  localparam int MAXC  = (ALE_CYC > STB_CYC) ? ALE_CYC : STB_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  xbus_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ext) begin
          state_d = ST_ADDR;
          cnt_d   = CNT_W'(ALE_CYC - 1);
        end
      end
      ST_ADDR: begin
        if (cnt_q == '0) state_d = ST_HOLD;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_HOLD: begin
        state_d = ST_STRB;
        cnt_d   = CNT_W'(STB_CYC - 1);
      end
      ST_STRB: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state     = state_q;
  assign last_strb = (state_q == ST_STRB) && (cnt_q == '0);
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  xbus_state_e       state,
  input  logic [1:0]        kind_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n
);
  logic addr_phase;
  logic strb_phase;

  always_comb begin
    addr_phase = (state == ST_ADDR) || (state == ST_HOLD);
    strb_phase = (state == ST_STRB);
    ale    = (state == ST_ADDR);
    ad_out = addr_phase ? addr_q[DATA_W-1:0] : wdata_q;
    ad_oe  = addr_phase || (strb_phase && (kind_q == KIND_WRITE));
    a_hi   = addr_q[ADDR_W-1:DATA_W];
    psen_n = !(strb_phase && (kind_q == KIND_FETCH));
    rd_n   = !(strb_phase && (kind_q == KIND_READ));
    wr_n   = !(strb_phase && (kind_q == KIND_WRITE));
  end
endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int ROM_AW  = 12,
  parameter int ALE_CYC = 2,
  parameter int STB_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ext_access,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_data,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n
);
  xbus_state_e state;
  logic last_strb;
  logic go_internal;
  logic accept, start_ext, start_int;

  logic [1:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;
  logic              done_q, done_d;

  xbus_steer #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW)) u_steer (
    .kind        (req_kind),
    .addr        (req_addr),
    .ext_access  (ext_access),
    .go_internal (go_internal)
  );

  always_comb begin
    accept    = req_valid && (state == ST_IDLE);
    start_int = accept && go_internal;
    start_ext = accept && !go_internal;
  end

  xbus_seq #(.ALE_CYC(ALE_CYC), .STB_CYC(STB_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ext (start_ext),
    .state     (state),
    .last_strb (last_strb)
  );

  // Request capture for the external access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= KIND_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start_ext) begin
      kind_q  <= req_kind;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // Result and completion: the internal ROM answers in the accept cycle, the bus at the last strobe cycle.
  always_comb begin
    rdata_en = start_int || (last_strb && (kind_q != KIND_WRITE));
    rdata_d  = start_int ? rom_data : ad_in;
    done_d   = start_int || last_strb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (rdata_en) rdata_q <= rdata_d;
      done_q <= done_d;
    end
  end

  xbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .state   (state),
    .kind_q  (kind_q),
    .addr_q  (addr_q),
    .wdata_q (wdata_q),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .a_hi    (a_hi),
    .ale     (ale),
    .psen_n  (psen_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n)
  );

  assign rom_addr = req_addr[ROM_AW-1:0];
  assign busy     = (state != ST_IDLE);
  assign done     = done_q;
  assign rdata    = rdata_q;
endmodule

// File: rtl/xbus_checker.sv
module xbus_checker #(
  parameter int HI_W    = 8,
  parameter int STB_CYC = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            ad_oe,
  input logic [HI_W-1:0] a_hi,
  input logic            ale,
  input logic            psen_n,
  input logic            rd_n,
  input logic            wr_n
);
  logic any_low;
  logic [7:0] low_run;

  assign any_low = !psen_n || !rd_n || !wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_run <= '0;
    else if (any_low) low_run <= (low_run == 8'hFF) ? low_run : low_run + 8'd1;
    else              low_run <= '0;
  end

  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_n, !rd_n, !wr_n}) <= 1);

  assert_ale_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n));

  assert_strobe_after_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(psen_n) || $fell(rd_n) || $fell(wr_n)) |-> !$past(ale));

  assert_strobe_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(low_run) <= STB_CYC);

  assert_write_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  assert_read_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !psen_n) |-> !ad_oe);

  assert_done_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (psen_n && rd_n && wr_n && !ale));

  assert_hi_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(a_hi));

  assert_strobe_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (any_low || ale) |-> busy);

  always_comb begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (psen_n && rd_n && wr_n && !ale && !busy);
    end
  end
endmodule

bind xmem_bus_ctrl xbus_checker #(.HI_W(ADDR_W - DATA_W), .STB_CYC(STB_CYC)) u_xbus_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy),
  .done   (done),
  .ad_oe  (ad_oe),
  .a_hi   (a_hi),
  .ale    (ale),
  .psen_n (psen_n),
  .rd_n   (rd_n),
  .wr_n   (wr_n)
);

// File: tb/xmem_bus_ctrl_bench.sv
module xmem_bus_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ALE_CYC = 2;
  localparam int STB_CYC = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        ext_access;
  logic        busy, done;
  logic [7:0]  rdata;
  logic [11:0] rom_addr;
  logic [7:0]  rom_data;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  ad_in;
  logic [7:0]  a_hi;
  logic        ale, psen_n, rd_n, wr_n;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] lat_lo;

  always #(CLK_PERIOD/2) clk = ~clk;

  xmem_bus_ctrl #(.ALE_CYC(ALE_CYC), .STB_CYC(STB_CYC)) u_xmem_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .ext_access(ext_access),
    .busy(busy), .done(done), .rdata(rdata), .rom_addr(rom_addr),
    .rom_data(rom_data), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .a_hi(a_hi), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  function automatic logic [7:0] rom_model(input logic [11:0] a);
    return a[7:0] ^ {4'h0, a[11:8]} ^ 8'hC3;
  endfunction

  function automatic logic [7:0] ext_model(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // Behavioural on-chip ROM and external memory with an address latch.
  always_comb rom_data = rom_model(rom_addr);
  always @(posedge clk) if (ale) lat_lo <= ad_out;
  always_comb ad_in = (!psen_n || !rd_n) ? ext_model({a_hi, lat_lo}) : 8'hEE;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pick_addr(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0FFF;
      2: return 16'h1000;
      3: return 16'hFFFF;
      4: return 16'h0800;
      5: return 16'h7A5C;
      default: return 16'(i * 16'h0FF1);
    endcase
  endfunction

  task automatic run_acc(input int kind, input logic [15:0] a, input logic [7:0] wd, input logic ea);
    bit intl;
    logic [2:0] exp_n;
    intl  = (kind == 0) && ea && (a < 16'h1000);
    exp_n = (kind == 0) ? 3'b011 : (kind == 1) ? 3'b101 : 3'b110;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'(kind); req_addr = a; req_wdata = wd; ext_access = ea;
    #1;
    if (kind == 0) chk(rom_addr == a[11:0], "R3 rom_addr", 32'(rom_addr), 32'(a[11:0]));
    @(negedge clk);
    req_valid = 1'b0;
    if (intl) begin
      chk(done == 1'b1, "R3 done", 32'(done), 1);
      chk(rdata == rom_model(a[11:0]), "R3 rdata", 32'(rdata), 32'(rom_model(a[11:0])));
      chk(psen_n && rd_n && wr_n && !ale && !busy, "R3 quiet bus",
          32'({psen_n, rd_n, wr_n, ale, busy}), 32'b11100);
    end else begin
      for (int i = 0; i < ALE_CYC; i++) begin
        chk(ale && ad_oe && ad_out == a[7:0], "R5 address phase", 32'({ale, ad_oe, ad_out}),
            32'({2'b11, a[7:0]}));
        chk(a_hi == a[15:8], "R5 a_hi", 32'(a_hi), 32'(a[15:8]));
        chk({psen_n, rd_n, wr_n} == 3'b111 && busy, "R10 busy no strobe",
            32'({psen_n, rd_n, wr_n, busy}), 32'b1111);
        @(negedge clk);
      end
      chk(!ale && ad_oe && ad_out == a[7:0] && {psen_n, rd_n, wr_n} == 3'b111, "R6 hold cycle",
          32'({ale, ad_oe, ad_out, psen_n, rd_n, wr_n}), 32'({2'b01, a[7:0], 3'b111}));
      @(negedge clk);
      for (int i = 0; i < STB_CYC; i++) begin
        chk({psen_n, rd_n, wr_n} == exp_n && !ale,
            (kind == 0) ? (ea ? "R4 psen strobe" : "R2 psen strobe") : "R11 data strobe",
            32'({psen_n, rd_n, wr_n}), 32'(exp_n));
        chk(a_hi == a[15:8] && busy, "R5 a_hi in strobe", 32'(a_hi), 32'(a[15:8]));
        if (kind == 2) chk(ad_oe && ad_out == wd, "R8 write data", 32'({ad_oe, ad_out}), 32'({1'b1, wd}));
        else           chk(!ad_oe, "R9 port released", 32'(ad_oe), 0);
        if (i == 0) begin
          req_valid = 1'b1; req_kind = 2'd2; req_addr = ~a;
        end
        @(negedge clk);
        req_valid = 1'b0;
      end
      chk(done && !busy && {psen_n, rd_n, wr_n} == 3'b111, "R9 done after strobe",
          32'({done, busy, psen_n, rd_n, wr_n}), 32'b10111);
      if (kind != 2) chk(rdata == ext_model(a), "R9 rdata", 32'(rdata), 32'(ext_model(a)));
    end
    @(negedge clk);
    chk(!done && !ale && !busy, "R10 ignored request left no access",
        32'({done, ale, busy}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0; req_addr = '0; req_wdata = '0; ext_access = 1'b0;
    repeat (3) @(negedge clk);
    chk(psen_n && rd_n && wr_n && !ale && !ad_oe && !busy && !done, "R1 in reset",
        32'({psen_n, rd_n, wr_n, ale, ad_oe, busy, done}), 32'b1110000);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(psen_n && rd_n && wr_n && !ale && !ad_oe && !busy && !done, "R1 after reset",
        32'({psen_n, rd_n, wr_n, ale, ad_oe, busy, done}), 32'b1110000);
    for (int ea = 0; ea < 2; ea++)
      for (int k = 0; k < 3; k++)
        for (int i = 0; i < 14; i++)
          run_acc(k, pick_addr(i), 8'(i * 37 + k), ea[0]);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule